// File: doc/BRIEF.md
# Repeated-Character Escape Sequence Detector

This block watches the stream of characters coming out of a serial receiver together with a tick that marks each bit time. It looks for an escape sequence: one programmable character sent back to back at least a programmable number of times. The line must be quiet for a while before the burst. The characters of the burst must follow each other closely. The line must be quiet again for a while after the burst. When all of these hold, the block raises a single-cycle pulse that feeds the command-character bit (bit 18) of the UART interrupt vector.

One idle counter measures all three time conditions in bit-time ticks. Any received character restarts it. A run counter holds the number of accepted target characters. A control module compares both counters against the configuration and issues clear, start and increment strobes. It also registers the detect pulse.

Top module: `esc_seq_detect`

## Requirements
- R1: While reset is low and on the first cycle after it, detectPulse is 0. After reset the line counts as busy: the idle count starts at 0.
- R2: Only characters equal to cfgChar count toward a run. A run of cfgCount target characters produces exactly one pulse.
- R3: A run shorter than cfgCount never produces a pulse, however long the line then stays idle.
- R4: A run longer than cfgCount still produces exactly one pulse.
- R5: A target character that arrives when cfgGap or more ticks have passed since the previous character does not extend the run (cfgGap non-zero). It is treated as the first character of a new run.
- R6: A target character can start a run only if at least cfgPreIdle ticks have passed since the previous received character of any value.
- R7: The pulse is raised in the cycle after the idle count first reaches cfgPostIdle following the last target character. It is never raised earlier.
- R8: A non-target character clears the run and restarts the idle count.
- R9: A target character received while the run is waiting for post-idle extends the run and restarts the post-idle wait.
- R10: A timer value of 0 means that condition always holds. A cfgCount of 0 behaves as 1.
- R11: A character received in the cycle where a detection would fire takes priority. The pulse is deferred and that character is added to the run.
- R12: detectPulse is never high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| chrValid | input | 1 | One-cycle strobe: a character was received |
| chrData | input | DATA_W | Received character |
| bitTick | input | 1 | One-cycle strobe per bit time |
| cfgChar | input | DATA_W | Target character |
| cfgCount | input | COUNT_W | Minimum number of target characters |
| cfgGap | input | TIMER_W | Maximum gap between target characters, in ticks (0 = unlimited) |
| cfgPreIdle | input | TIMER_W | Idle ticks needed before the first target character |
| cfgPostIdle | input | TIMER_W | Idle ticks needed after the last target character |
| detectPulse | output | 1 | One-cycle detection pulse |

## Verification
The main function is driven with several kinds of burst: runs exactly at the threshold, runs one short and runs longer than it. These separate a correct comparison from one that is off by one or that fires repeatedly. Further bursts are broken by a foreign character, or arrive too soon after earlier traffic, or have one gap just at the limit and one just under it. These show that each timing qualifier is applied on its own terms. A burst is also extended during the post-idle wait, and another is sent back to back with all timers at zero. These two show the restart of the post-idle wait and the priority of a character over a detection in the same cycle. Post-idle expiry is sampled at the exact cycle of the pulse and at the cycle before it.

// File: rtl/esc_seq_pkg.sv
package esc_seq_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic idleClear;
    logic runClear;
    logic runStart;
    logic runInc;
  } ctrlStrobes_t;

  // Comparison results from datapath to control
  typedef struct packed {
    logic isTarget;
    logic runActive;
    logic runMet;
    logic preOk;
    logic gapOk;
    logic postOk;
  } dpStatus_t;

endpackage

// File: rtl/esc_seq_datapath.sv
module esc_seq_datapath
  import esc_seq_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int COUNT_W = 8,
  parameter int TIMER_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobes_t       strobes,
  input  logic               bitTick,
  input  logic [DATA_W-1:0]  chrData,
  input  logic [DATA_W-1:0]  cfgChar,
  input  logic [COUNT_W-1:0] cfgCount,
  input  logic [TIMER_W-1:0] cfgGap,
  input  logic [TIMER_W-1:0] cfgPreIdle,
  input  logic [TIMER_W-1:0] cfgPostIdle,
  output dpStatus_t          status
);

  localparam logic [TIMER_W-1:0] IDLE_MAX = {TIMER_W{1'b1}};
  localparam logic [COUNT_W-1:0] RUN_MAX  = {COUNT_W{1'b1}};
  localparam logic [COUNT_W-1:0] RUN_ONE  = COUNT_W'(1);

  logic [TIMER_W-1:0] idleCnt;
  logic [COUNT_W-1:0] runCnt;
  logic [COUNT_W-1:0] countNeed;

  // Ticks since the last received character, saturating
  always_ff @(posedge clk) begin
    if (!rstN)                              idleCnt <= '0;
    else if (strobes.idleClear)             idleCnt <= '0;
    else if (bitTick && idleCnt != IDLE_MAX) idleCnt <= idleCnt + 1'b1;
  end

  // Accepted target characters in the current run, saturating
  always_ff @(posedge clk) begin
    if (!rstN)                                  runCnt <= '0;
    else if (strobes.runClear)                  runCnt <= '0;
    else if (strobes.runStart)                  runCnt <= RUN_ONE;
    else if (strobes.runInc && runCnt != RUN_MAX) runCnt <= runCnt + 1'b1;
  end

  assign countNeed = (cfgCount == '0) ? RUN_ONE : cfgCount;

  always_comb begin
    status.isTarget  = (chrData == cfgChar);
    status.runActive = (runCnt != '0);
    status.runMet    = (runCnt >= countNeed);
    status.preOk     = (idleCnt >= cfgPreIdle);
    status.gapOk     = (cfgGap == '0) || (idleCnt < cfgGap);
    status.postOk    = (idleCnt >= cfgPostIdle);
  end

endmodule

// File: rtl/esc_seq_control.sv
module esc_seq_control
  import esc_seq_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         chrValid,
  input  dpStatus_t    status,
  output ctrlStrobes_t strobes,
  output logic         detectPulse
);

  logic fire;

  // A character in the same cycle takes priority over a detection
  assign fire = status.runActive && status.runMet && status.postOk && !chrValid;

  always_comb begin
    strobes = '0;
    strobes.idleClear = chrValid;
    if (chrValid) begin
      if (status.isTarget) begin
        if (status.runActive && status.gapOk) strobes.runInc   = 1'b1;
        else if (status.preOk)                strobes.runStart = 1'b1;
        else                                  strobes.runClear = 1'b1;
      end else begin
        strobes.runClear = 1'b1;
      end
    end else if (fire) begin
      strobes.runClear = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) detectPulse <= 1'b0;
    else       detectPulse <= fire;
  end

endmodule

// File: rtl/esc_seq_detect.sv
module esc_seq_detect
  import esc_seq_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int COUNT_W = 8,
  parameter int TIMER_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               chrValid,
  input  logic [DATA_W-1:0]  chrData,
  input  logic               bitTick,
  input  logic [DATA_W-1:0]  cfgChar,
  input  logic [COUNT_W-1:0] cfgCount,
  input  logic [TIMER_W-1:0] cfgGap,
  input  logic [TIMER_W-1:0] cfgPreIdle,
  input  logic [TIMER_W-1:0] cfgPostIdle,
  output logic               detectPulse
);

  ctrlStrobes_t strobes;
  dpStatus_t    status;

  esc_seq_datapath #(
    .DATA_W(DATA_W), .COUNT_W(COUNT_W), .TIMER_W(TIMER_W)
  ) i_datapath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .bitTick(bitTick),
    .chrData(chrData), .cfgChar(cfgChar), .cfgCount(cfgCount),
    .cfgGap(cfgGap), .cfgPreIdle(cfgPreIdle), .cfgPostIdle(cfgPostIdle),
    .status(status)
  );

  esc_seq_control i_control (
    .clk(clk), .rstN(rstN), .chrValid(chrValid), .status(status),
    .strobes(strobes), .detectPulse(detectPulse)
  );

endmodule

// File: rtl/esc_seq_checker.sv
module esc_seq_checker #(
  parameter int TIMER_W = 16
) (
  input logic               clk,
  input logic               rstN,
  input logic               chrValid,
  input logic [TIMER_W-1:0] cfgPostIdle,
  input logic               detectPulse
);

  AST_RESET_QUIET: assert property (@(posedge clk) !rstN |=> !detectPulse); // R1

  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    detectPulse |=> !detectPulse); // R12

  AST_CHAR_PRIORITY: assert property (@(posedge clk) disable iff (!rstN)
    detectPulse |-> !$past(chrValid)); // R11

  AST_POST_IDLE_GAP: assert property (@(posedge clk) disable iff (!rstN)
    (detectPulse && cfgPostIdle != '0 && $past(rstN, 2)) |-> !$past(chrValid, 2)); // R7

endmodule

bind esc_seq_detect esc_seq_checker #(.TIMER_W(TIMER_W)) i_checker (
  .clk(clk), .rstN(rstN), .chrValid(chrValid),
  .cfgPostIdle(cfgPostIdle), .detectPulse(detectPulse)
);

// File: tb/test_esc_seq_detect.sv
module test_esc_seq_detect;

  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 8, COUNT_W = 8, TIMER_W = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic chrValid = 1'b0;
  logic [DATA_W-1:0] chrData = '0;
  logic bitTick = 1'b0;
  logic [DATA_W-1:0] cfgChar = 8'h2B;
  logic [COUNT_W-1:0] cfgCount = 8'd3;
  logic [TIMER_W-1:0] cfgGap = 16'd5;
  logic [TIMER_W-1:0] cfgPreIdle = 16'd2;
  logic [TIMER_W-1:0] cfgPostIdle = 16'd4;
  logic detectPulse;

  int checks = 0, errors = 0, pulseCount = 0, backToBack = 0;
  logic prevPulse = 1'b0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  esc_seq_detect #(.DATA_W(DATA_W), .COUNT_W(COUNT_W), .TIMER_W(TIMER_W)) i_esc_seq_detect (
    .clk(clk), .rstN(rstN), .chrValid(chrValid), .chrData(chrData), .bitTick(bitTick),
    .cfgChar(cfgChar), .cfgCount(cfgCount), .cfgGap(cfgGap), .cfgPreIdle(cfgPreIdle),
    .cfgPostIdle(cfgPostIdle), .detectPulse(detectPulse)
  );

  always @(negedge clk) begin
    if (detectPulse) pulseCount++;
    if (detectPulse && prevPulse) backToBack++;
    prevPulse = detectPulse;
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One clock with the given inputs; ends just after a falling edge
  task automatic step(logic v, logic [DATA_W-1:0] d, logic t);
    chrValid = v; chrData = d; bitTick = t;
    @(negedge clk); #1;
    chrValid = 1'b0; bitTick = 1'b0;
  endtask

  task automatic sendChar(logic [DATA_W-1:0] d); step(1'b1, d, 1'b0); endtask
  task automatic ticks(int n); for (int i = 0; i < n; i++) step(1'b0, '0, 1'b1); endtask
  task automatic idle(int n); for (int i = 0; i < n; i++) step(1'b0, '0, 1'b0); endtask

  task automatic setup(logic [COUNT_W-1:0] cnt, logic [TIMER_W-1:0] gap,
                       logic [TIMER_W-1:0] pre, logic [TIMER_W-1:0] post);
    sendChar(8'h00);
    cfgCount = cnt; cfgGap = gap; cfgPreIdle = pre; cfgPostIdle = post;
    ticks(8);
  endtask

  task automatic testReset();
    check("R1 pulse in reset", detectPulse, 0);
    rstN = 1'b1;
    idle(1);
    check("R1 pulse after reset", detectPulse, 0);
    // line busy after reset: pre-idle 2 not yet met
    sendChar(cfgChar); sendChar(cfgChar); sendChar(cfgChar);
    ticks(6); idle(1);
    check("R1 no run without pre-idle after reset", pulseCount, 0);
  endtask

  task automatic testExactPostIdle();
    int base;
    setup(3, 5, 2, 4);
    base = pulseCount;
    repeat (3) sendChar(cfgChar);
    ticks(3); idle(1);
    check("R7 no pulse before post-idle", detectPulse, 0);
    ticks(1);
    check("R7 no pulse on reaching tick", detectPulse, 0);
    idle(1);
    check("R7 pulse cycle after post-idle reached", detectPulse, 1);
    idle(1);
    check("R12 pulse one cycle wide", detectPulse, 0);
    ticks(6);
    check("R2 exactly one pulse", pulseCount - base, 1);
  endtask

  task automatic testShortRun();
    int base;
    setup(3, 5, 2, 4);
    base = pulseCount;
    repeat (2) sendChar(cfgChar);
    ticks(12); idle(2);
    check("R3 short run no pulse", pulseCount - base, 0);
  endtask

  task automatic testLongRun();
    int base;
    setup(3, 5, 2, 4);
    base = pulseCount;
    repeat (6) sendChar(cfgChar);
    ticks(10); idle(2);
    check("R4 long run one pulse", pulseCount - base, 1);
  endtask

  task automatic testOtherChar();
    int base;
    setup(3, 5, 2, 2);
    base = pulseCount;
    cfgChar = 8'h5A;
    repeat (3) sendChar(8'h2B);
    ticks(4); idle(1);
    check("R2 non-matching char ignored", pulseCount - base, 0);
    ticks(4);
    repeat (3) sendChar(8'h5A);
    ticks(3); idle(1);
    check("R2 programmed char detected", pulseCount - base, 1);
    cfgChar = 8'h2B;
  endtask

  task automatic testForeignBreak();
    int base;
    setup(3, 5, 0, 2);
    base = pulseCount;
    sendChar(cfgChar); sendChar(cfgChar); sendChar(8'h41);
    sendChar(cfgChar); sendChar(cfgChar);
    ticks(4); idle(1);
    check("R8 foreign char clears run", pulseCount - base, 0);
    sendChar(cfgChar); sendChar(cfgChar); sendChar(8'h41);
    repeat (3) sendChar(cfgChar);
    ticks(3); idle(1);
    check("R8 fresh run after foreign char", pulseCount - base, 1);
  endtask

  task automatic testPreIdle();
    int base;
    setup(3, 5, 3, 2);
    base = pulseCount;
    sendChar(8'h41); ticks(2);
    repeat (3) sendChar(cfgChar);
    ticks(4); idle(1);
    check("R6 pre-idle too short", pulseCount - base, 0);
    sendChar(8'h41); ticks(3);
    repeat (3) sendChar(cfgChar);
    ticks(3); idle(1);
    check("R6 pre-idle just met", pulseCount - base, 1);
  endtask

  task automatic testGap();
    int base;
    setup(3, 3, 0, 2);
    base = pulseCount;
    sendChar(cfgChar); ticks(3); sendChar(cfgChar); ticks(2); sendChar(cfgChar);
    ticks(3); idle(1);
    check("R5 late char restarts run", pulseCount - base, 0);
    setup(3, 3, 0, 2);
    base = pulseCount;
    sendChar(cfgChar); ticks(2); sendChar(cfgChar); ticks(2); sendChar(cfgChar);
    ticks(2); idle(1);
    check("R5 gaps within limit accepted", pulseCount - base, 1);
  endtask

  task automatic testExtend();
    int base;
    setup(2, 0, 0, 4);
    base = pulseCount;
    sendChar(cfgChar); sendChar(cfgChar);
    ticks(3);
    sendChar(cfgChar);
    ticks(3); idle(1);
    check("R9 post-idle restarted by target char", pulseCount - base, 0);
    ticks(1); idle(1);
    check("R9 pulse after restarted wait", detectPulse, 1);
    idle(3);
    check("R9 single pulse for extended run", pulseCount - base, 1);
  endtask

  task automatic testZeroAndPriority();
    int base;
    setup(0, 0, 0, 0);
    base = pulseCount;
    sendChar(cfgChar);
    check("R10 no pulse in char cycle", detectPulse, 0);
    idle(1);
    check("R10 zero timers and count fire next cycle", detectPulse, 1);
    setup(2, 0, 0, 0);
    base = pulseCount;
    sendChar(cfgChar); sendChar(cfgChar);
    sendChar(cfgChar);
    check("R11 detect deferred by char", detectPulse, 0);
    idle(1);
    check("R11 pulse once chars stop", detectPulse, 1);
    idle(3);
    check("R11 one pulse for the burst", pulseCount - base, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    testReset();
    testExactPostIdle();
    testShortRun();
    testLongRun();
    testOtherChar();
    testForeignBreak();
    testPreIdle();
    testGap();
    testExtend();
    testZeroAndPriority();
    check("R12 no back-to-back pulses", backToBack, 0);
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual %0d expected %0d", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule